// File: doc/BRIEF.md
# Segment Register Protection Checker

This block keeps a bank of sixteen 32-bit segment registers and judges each memory access against them. The upper four bits of the effective address pick one register. That register supplies three things: a 24-bit virtual segment identifier, a pair of protection keys (one for each privilege level) and a no-execute bit.

For each access, the key that matches the current privilege level is combined with a 2-bit page protection code that arrives with the access. Together they decide whether a load, a store or an instruction fetch is allowed. The result is a registered response. It carries the segment identifier and three mutually exclusive flags: no-execute fault, protection fault, and unsupported segment (the direct-store bit is set).

Registers are loaded through a simple index-and-data write port. Page table walks and exception delivery are left to the surrounding logic.

Top module: `seg_prot_unit`

## Requirements
- R1: After reset every segment register reads as zero, so a lookup returns identifier 0 with no flag raised for any load.
- R2: When `wr_en` is high, `wr_data` is stored into register `wr_idx` at the clock edge. A lookup issued in the same cycle sees the register's previous contents.
- R3: The register is selected by `req_ea[31:28]`. `rsp_vsid` equals bits [23:0] of that register. Bits [27:24] have no effect.
- R4: Register bit 30 is the key when `req_user` is 0. Register bit 29 is the key when `req_user` is 1.
- R5: With key 0, every access is allowed for protection codes 00, 01 and 10. For code 11, a store raises `rsp_prot_fault`, while loads and fetches are allowed.
- R6: With key 1, code 00 denies every access. Codes 01 and 11 deny stores only. Code 10 allows every access.
- R7: If register bit 28 is set, a fetch raises `rsp_nx_fault` and never `rsp_prot_fault`. This holds even when the rights would deny the fetch. Loads and stores are not affected by bit 28.
- R8: If register bit 31 is set, `rsp_unsup` is raised and both other fault flags stay low. `rsp_vsid` is still reported.
- R9: A response appears with `rsp_valid` exactly one cycle after `req_valid`. While `rsp_valid` is low, all response outputs are zero. At most one flag is high at any time.
- R10: Access codes on `req_acc` are 00 load, 01 store and 10 fetch. Code 11 is handled as a load. A fetch uses read rights.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Segment register write strobe |
| wr_idx | input | 4 | Register number to write |
| wr_data | input | 32 | Value to write |
| req_valid | input | 1 | Access check request |
| req_ea | input | 32 | Effective address |
| req_acc | input | 2 | Access type |
| req_user | input | 1 | 1 = user level, 0 = supervisor level |
| req_pp | input | 2 | Page protection code |
| rsp_valid | output | 1 | Response valid |
| rsp_vsid | output | 24 | Virtual segment identifier |
| rsp_nx_fault | output | 1 | Fetch from a no-execute segment |
| rsp_prot_fault | output | 1 | Access denied by key and protection code |
| rsp_unsup | output | 1 | Direct-store segment, not supported |

## Verification
Every response is due exactly one rising edge after its request. A register write is visible to requests made from the cycle after the write edge.

The bench drives inputs on the falling edge and samples the response at the following falling edge. This places each check half a period after the single register stage.

The same-cycle case, where a write and a request happen together, is sampled in the same way and expects the old register contents. A back-to-back pair confirms that `rsp_valid` falls one edge after `req_valid`.

// File: rtl/seg_prot_pkg.sv
package seg_prot_pkg;

   typedef enum logic [1:0] {
      ACC_LOAD  = 2'b00,
      ACC_STORE = 2'b01,
      ACC_FETCH = 2'b10,
      ACC_RSVD  = 2'b11
   } acc_e;

   // Allowed when key/protection permit; only stores are ever treated
   // differently from loads and fetches.
   function automatic logic rights_ok(input logic key, input logic [1:0] pp,
                                      input logic is_store);
      logic ok;
      if (key)
         ok = (pp == 2'b10) || ((pp != 2'b00) && !is_store);
      else
         ok = !((pp == 2'b11) && is_store);
      return ok;
   endfunction

endpackage

// File: rtl/seg_reg_bank.sv
module seg_reg_bank #(
   parameter int DATA_W = 32,
   parameter int IDX_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data
);
   localparam int NUM_SEG = 1 << IDX_W;

   logic [DATA_W-1:0] regs [NUM_SEG];

   for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            regs[g] <= '0;
         else if (wr_en && (wr_idx == IDX_W'(g)))
            regs[g] <= wr_data;
      end
   end

   assign rd_data = regs[rd_idx];

endmodule

// File: rtl/seg_rights.sv
module seg_rights #(
   parameter bit USE_TABLE = 1'b1
) (
   input  logic       key,
   input  logic [1:0] pp,
   input  logic       is_store,
   output logic       allowed
);
   import seg_prot_pkg::*;

   if (USE_TABLE) begin : g_table
      logic [15:0] tbl;
      always_comb begin
         for (int i = 0; i < 8; i++)
            tbl[i] = rights_ok(i[2], i[1:0], 1'b0);
         for (int i = 0; i < 8; i++)
            tbl[8+i] = rights_ok(i[2], i[1:0], 1'b1);
      end
      assign allowed = tbl[{is_store, key, pp}];
   end else begin : g_logic
      assign allowed = rights_ok(key, pp, is_store);
   end

endmodule

// File: rtl/seg_prot_unit.sv
module seg_prot_unit #(
   parameter int DATA_W    = 32,
   parameter int EA_W      = 32,
   parameter int IDX_W     = 4,
   parameter int VSID_W    = 24,
   parameter bit USE_TABLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              req_valid,
   input  logic [EA_W-1:0]   req_ea,
   input  logic [1:0]        req_acc,
   input  logic              req_user,
   input  logic [1:0]        req_pp,
   output logic              rsp_valid,
   output logic [VSID_W-1:0] rsp_vsid,
   output logic              rsp_nx_fault,
   output logic              rsp_prot_fault,
   output logic              rsp_unsup
);
   import seg_prot_pkg::*;

   localparam int T_BIT  = DATA_W - 1;
   localparam int KS_BIT = DATA_W - 2;
   localparam int KU_BIT = DATA_W - 3;
   localparam int NX_BIT = DATA_W - 4;

   if (VSID_W + 4 > DATA_W) begin : g_bad_vsid
      $error("VSID_W too wide for DATA_W");
   end
   if (IDX_W > EA_W) begin : g_bad_idx
      $error("IDX_W exceeds EA_W");
   end

   logic [DATA_W-1:0] sel_reg;
   logic              key, is_store, is_fetch, allowed;
   logic              nx_d, prot_d, unsup_d;

   seg_reg_bank #(.DATA_W(DATA_W), .IDX_W(IDX_W)) bank_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_data (wr_data),
      .rd_idx  (req_ea[EA_W-1 -: IDX_W]),
      .rd_data (sel_reg)
   );

   assign key      = req_user ? sel_reg[KU_BIT] : sel_reg[KS_BIT];
   assign is_store = (acc_e'(req_acc) == ACC_STORE);
   assign is_fetch = (acc_e'(req_acc) == ACC_FETCH);

   seg_rights #(.USE_TABLE(USE_TABLE)) rights_i (
      .key      (key),
      .pp       (req_pp),
      .is_store (is_store),
      .allowed  (allowed)
   );

   always_comb begin
      unsup_d = sel_reg[T_BIT];
      nx_d    = !unsup_d && is_fetch && sel_reg[NX_BIT];
      prot_d  = !unsup_d && !nx_d && !allowed;
   end

   logic [NX_BIT-VSID_W-1:0] unused_fields;
   logic [EA_W-IDX_W-1:0]    unused_ea;
   assign unused_fields = sel_reg[NX_BIT-1:VSID_W];
   assign unused_ea     = req_ea[EA_W-IDX_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid      <= 1'b0;
         rsp_vsid       <= '0;
         rsp_nx_fault   <= 1'b0;
         rsp_prot_fault <= 1'b0;
         rsp_unsup      <= 1'b0;
      end else begin
         rsp_valid      <= req_valid;
         rsp_vsid       <= req_valid ? sel_reg[VSID_W-1:0] : '0;
         rsp_nx_fault   <= req_valid && nx_d;
         rsp_prot_fault <= req_valid && prot_d;
         rsp_unsup      <= req_valid && unsup_d;
      end
   end

endmodule

// File: rtl/seg_prot_unit_chk.sv
module seg_prot_unit_chk #(
   parameter int VSID_W = 24
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [1:0]        req_acc,
   input logic [1:0]        req_pp,
   input logic              rsp_valid,
   input logic [VSID_W-1:0] rsp_vsid,
   input logic              rsp_nx_fault,
   input logic              rsp_prot_fault,
   input logic              rsp_unsup
);
   p_one_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rsp_nx_fault, rsp_prot_fault, rsp_unsup}));

   p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> (rsp_vsid == '0) && !rsp_nx_fault && !rsp_prot_fault && !rsp_unsup);

   p_nx_fetch_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_acc != 2'b10) |=> !rsp_nx_fault);

   p_pp10_open_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_pp == 2'b10) |=> !rsp_prot_fault);

endmodule

bind seg_prot_unit seg_prot_unit_chk #(.VSID_W(VSID_W)) chk_i (
   .clk            (clk),
   .rst_n          (rst_n),
   .req_valid      (req_valid),
   .req_acc        (req_acc),
   .req_pp         (req_pp),
   .rsp_valid      (rsp_valid),
   .rsp_vsid       (rsp_vsid),
   .rsp_nx_fault   (rsp_nx_fault),
   .rsp_prot_fault (rsp_prot_fault),
   .rsp_unsup      (rsp_unsup)
);

// File: tb/seg_prot_unit_tb.sv
module seg_prot_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_idx = '0;
   logic [31:0] wr_data = '0;
   logic        req_valid = 1'b0;
   logic [31:0] req_ea = '0;
   logic [1:0]  req_acc = '0;
   logic        req_user = 1'b0;
   logic [1:0]  req_pp = '0;
   logic        rsp_valid;
   logic [23:0] rsp_vsid;
   logic        rsp_nx_fault, rsp_prot_fault, rsp_unsup;

   int n_checks = 0;
   int n_fail   = 0;

   always #4 clk = ~clk;

   seg_prot_unit dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_data(wr_data), .req_valid(req_valid), .req_ea(req_ea),
      .req_acc(req_acc), .req_user(req_user), .req_pp(req_pp),
      .rsp_valid(rsp_valid), .rsp_vsid(rsp_vsid),
      .rsp_nx_fault(rsp_nx_fault), .rsp_prot_fault(rsp_prot_fault),
      .rsp_unsup(rsp_unsup)
   );

   // expected outcome packed as {valid, vsid, nx, prot, unsup}
   function automatic logic [27:0] model(input logic [31:0] sr, input logic [1:0] acc,
                                         input logic user, input logic [1:0] pp);
      logic k, st, ok, nx, pf, un;
      k  = user ? sr[29] : sr[30];
      st = (acc == 2'b01);
      if (k) ok = (pp == 2'b10) || (pp != 2'b00 && !st);
      else   ok = !(pp == 2'b11 && st);
      un = sr[31];
      nx = !un && acc == 2'b10 && sr[28];
      pf = !un && !nx && !ok;
      return {1'b1, sr[23:0], nx, pf, un};
   endfunction

   task automatic check(input string req, input logic [27:0] exp);
      logic [27:0] act;
      act = {rsp_valid, rsp_vsid, rsp_nx_fault, rsp_prot_fault, rsp_unsup};
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic write_sr(input logic [3:0] idx, input logic [31:0] val);
      @(negedge clk);
      wr_en = 1'b1; wr_idx = idx; wr_data = val;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic lookup(input string req, input logic [31:0] ea, input logic [1:0] acc,
                         input logic user, input logic [1:0] pp, input logic [31:0] sr);
      @(negedge clk);
      req_valid = 1'b1; req_ea = ea; req_acc = acc; req_user = user; req_pp = pp;
      @(negedge clk);
      req_valid = 1'b0;
      check(req, model(sr, acc, user, pp));
   endtask

   task automatic t_reset();
      check("R1 idle", 28'h0);
      for (int i = 0; i < 16; i++)
         lookup("R1", {i[3:0], 28'h0}, 2'b01, 1'b0, 2'b00, 32'h0);
   endtask

   task automatic t_select();
      write_sr(4'h3, 32'h0F12_3456);
      write_sr(4'hC, 32'h00AB_CDEF);
      lookup("R3", 32'h3FFF_FFFF, 2'b00, 1'b0, 2'b00, 32'h0F12_3456);
      lookup("R3", 32'hC000_0000, 2'b00, 1'b0, 2'b00, 32'h00AB_CDEF);
      lookup("R3", 32'h4300_0000, 2'b00, 1'b0, 2'b00, 32'h0);
   endtask

   task automatic t_rights();
      for (int k = 0; k < 2; k++) begin
         logic [31:0] sr;
         sr = {1'b0, k[0], k[0], 5'b0, 24'h000111};
         write_sr(4'h5, sr);
         for (int pp = 0; pp < 4; pp++)
            for (int a = 0; a < 4; a++)
               lookup(k == 0 ? "R5 R10" : "R6 R10", 32'h5000_0000, a[1:0], 1'b0, pp[1:0], sr);
      end
   endtask

   task automatic t_key_sel();
      write_sr(4'h6, 32'h4000_0022); // supervisor key 1, user key 0
      lookup("R4", 32'h6000_0000, 2'b01, 1'b0, 2'b01, 32'h4000_0022);
      lookup("R4", 32'h6000_0000, 2'b01, 1'b1, 2'b01, 32'h4000_0022);
      write_sr(4'h6, 32'h2000_0022); // user key 1
      lookup("R4", 32'h6000_0000, 2'b00, 1'b1, 2'b00, 32'h2000_0022);
      lookup("R4", 32'h6000_0000, 2'b00, 1'b0, 2'b00, 32'h2000_0022);
   endtask

   task automatic t_noexec();
      write_sr(4'h7, 32'h7000_0077); // nx, both keys 1
      lookup("R7", 32'h7000_0000, 2'b10, 1'b0, 2'b00, 32'h7000_0077);
      lookup("R7", 32'h7000_0000, 2'b10, 1'b1, 2'b10, 32'h7000_0077);
      lookup("R7", 32'h7000_0000, 2'b00, 1'b0, 2'b10, 32'h7000_0077);
      lookup("R7", 32'h7000_0000, 2'b01, 1'b0, 2'b01, 32'h7000_0077);
   endtask

   task automatic t_unsup();
      write_sr(4'h8, 32'hF000_0088);
      lookup("R8", 32'h8000_0000, 2'b10, 1'b0, 2'b00, 32'hF000_0088);
      lookup("R8", 32'h8000_0000, 2'b01, 1'b1, 2'b11, 32'hF000_0088);
   endtask

   task automatic t_same_cycle();
      write_sr(4'h9, 32'h0000_1111);
      @(negedge clk);
      wr_en = 1'b1; wr_idx = 4'h9; wr_data = 32'h0000_2222;
      req_valid = 1'b1; req_ea = 32'h9000_0000; req_acc = 2'b00; req_user = 1'b0; req_pp = 2'b00;
      @(negedge clk);
      wr_en = 1'b0; req_valid = 1'b0;
      check("R2 old", model(32'h0000_1111, 2'b00, 1'b0, 2'b00));
      lookup("R2 new", 32'h9000_0000, 2'b00, 1'b0, 2'b00, 32'h0000_2222);
   endtask

   task automatic t_latency();
      @(negedge clk);
      req_valid = 1'b1; req_ea = 32'hC000_0000; req_acc = 2'b00; req_pp = 2'b00; req_user = 1'b0;
      @(negedge clk);
      req_valid = 1'b0; req_ea = 32'h3000_0000;
      check("R9 pulse", model(32'h00AB_CDEF, 2'b00, 1'b0, 2'b00));
      @(negedge clk);
      check("R9 idle", 28'h0);
   endtask

   initial begin
      #20000;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_select();
      t_rights();
      t_key_sel();
      t_noexec();
      t_unsup();
      t_same_cycle();
      t_latency();
      @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule